// File: doc/BRIEF.md
# Microwire serial EEPROM master

This block drives a three-wire serial EEPROM that holds 64 words of 16 bits each. A host issues one of three commands: read a word, write a word, or enable writes. Each command carries a word address and, for a write, a data word. The block turns the command into a bit-serial frame on chip select, serial clock and data-in. It gathers the read word from the device's data-out line. It signals the end of the command with a one-cycle `done` pulse. A programmable divider sets the serial clock. Every bit takes one low half-period and one high half-period, each `CLK_DIV` system clocks long. After a write, the block also waits a fixed, parameterised programming time before it reports completion.

Every frame opens with a dummy zero and then a start one. Two opcode bits and the address field follow. The write-enable command places a fixed `11` pattern at the top of the address field and fills the rest with zeros. As a result, all three commands carry a header of `ADDR_W+4` bits.

The controller is a six-state machine:

| State | Role |
|---|---|
| IDLE | Waits for a command. |
| SELECT | Raises chip select and holds it for one half-period. |
| LOW | Presents a bit on data-in with the clock low. |
| HIGH | Drives the clock high. |
| DESELECT | Drops chip select and waits three half-periods. |
| PROGRAM | Waits out the write programming time. |

The transitions are:

| Transition | Condition |
|---|---|
| IDLE→SELECT | A command is accepted. |
| SELECT→LOW | The half-period ends. |
| LOW→HIGH | The half-period ends. |
| HIGH→LOW | More bits remain. |
| HIGH→DESELECT | The last bit has been clocked. |
| DESELECT→PROGRAM | The command was a write. |
| DESELECT→IDLE | The command was a read or a write-enable. |
| PROGRAM→IDLE | The programming time ends. |

Top module: `mw_eeprom_master`

## Requirements
- R1: While reset (`rst_n` low) is held, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `rd_data` are all zero.
- R2: `cmd_op` selects the command: 2'b00 is read, 2'b01 is write, 2'b10 is write-enable and 2'b11 is reserved. A command is accepted only when `cmd_valid` is high and the block is idle. A reserved code, or any command presented while `busy` is high, starts no frame and has no effect.
- R3: A read frame is the bits 0,1,1,0 followed by the address MSB first, and then 16 further clocks with data-in low. On each of those 16 clocks, `ee_do` is sampled in the last system clock of the high half. The samples are assembled MSB first into `rd_data`.
- R4: A write frame is 0,1,0,1, then the address MSB first, then the 16 data bits MSB first, for `ADDR_W+20` clocks in total.
- R5: A write-enable frame is 0,1,0,0,1,1 followed by `ADDR_W-2` zeros, for `ADDR_W+4` clocks in total.
- R6: Each clock half-period lasts exactly `CLK_DIV` system clocks. `ee_di` never changes while `ee_sk` is high. `ee_sk` is high only while `ee_cs` is high.
- R7: Chip select rises `2*CLK_DIV` system clocks before the first clock rise. That is one select half-period plus the low half of the first bit. Chip select falls together with the last clock fall.
- R8: `done` appears exactly `4*CLK_DIV + 2*CLK_DIV*n` system clocks after the accepting edge, where `n` is the frame's clock count. For a write, `PROG_WAIT` more clocks are added.
- R9: `busy` is high from the accepting edge until `done`. `done` is a single-cycle pulse and coincides with `busy` low.
- R10: `rd_data` keeps its value across write and write-enable commands.
- R11: After a write, chip select stays low for `3*CLK_DIV + PROG_WAIT` system clocks before `done`. After a read or a write-enable, it stays low for `3*CLK_DIV`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Data word for a write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word returned by the last read |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
A wrong state or bit count shows up at the device pins within one frame. The monitor sees it as a frame with the wrong length or wrong content when chip select falls. The same fault also moves `done` away from the cycle the latency formula predicts. A fault in the read capture path shows up only in `rd_data` when `done` pulses. The bench therefore writes all 64 addresses with distinct words, then reads each one back. The half-period counter is checked through the measured run lengths of `ee_sk`. A fault in that counter shifts these lengths on the first bit of the first frame.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_EWEN  = 2'b10,
        OP_NONE  = 2'b11
    } mw_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SELECT,
        S_LOW,
        S_HIGH,
        S_DESELECT,
        S_PROGRAM
    } mw_state_e;

endpackage

// File: rtl/mw_frame_builder.sv
module mw_frame_builder
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    localparam int HDR_W   = ADDR_W + 4,
    localparam int FRAME_W = HDR_W + DATA_W,
    localparam int CW      = $clog2(FRAME_W + 1)
) (
    input  mw_op_e              op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [FRAME_W-1:0]  frame,
    output logic [CW-1:0]       nbits
);

    logic [HDR_W-1:0] hdr;

    // Header: dummy zero, start one, two opcode bits, address field.
    always_comb begin
        unique case (op)
            OP_READ:  hdr = {4'b0110, addr};
            OP_WRITE: hdr = {4'b0101, addr};
            OP_EWEN:  hdr = {4'b0100, 2'b11, {(ADDR_W-2){1'b0}}};
            OP_NONE:  hdr = '0;
        endcase
        frame = {hdr, (op == OP_WRITE) ? wdata : {DATA_W{1'b0}}};
        nbits = (op == OP_EWEN) ? CW'(HDR_W) : CW'(FRAME_W);
    end

endmodule

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_len,
    output logic          expire
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);

    // R8
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_len != '0));

endmodule

// File: rtl/mw_tx_shifter.sv
module mw_tx_shifter #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         head,
    output logic         head_next
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end
    end

    assign head      = sr_q[W-1];
    assign head_next = sr_q[W-2];

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int CLK_DIV   = 4,
    parameter int PROG_WAIT = 1500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);

    localparam int HDR_W     = ADDR_W + 4;
    localparam int FRAME_W   = HDR_W + DATA_W;
    localparam int CW        = $clog2(FRAME_W + 1);
    localparam int DESEL_LEN = 3 * CLK_DIV;
    localparam int MAX_LEN   = (PROG_WAIT > DESEL_LEN) ? PROG_WAIT : DESEL_LEN;
    localparam int TW        = $clog2(MAX_LEN + 1);

    mw_state_e state_q, state_d;
    mw_op_e    op_q;
    mw_op_e    cmd_op_e;
    logic [CW-1:0]      bit_left_q;
    logic [FRAME_W-1:0] frame;
    logic [CW-1:0]      nbits;
    logic [TW-1:0]      phase_len;
    logic               t_expire;
    logic               accept;
    logic               hi_end;
    logic               last_bit;
    logic               tx_head, tx_head_next;
    logic               cs_q, sk_q, di_q, done_q;
    logic [DATA_W-1:0]  rd_q;

    assign cmd_op_e = mw_op_e'(cmd_op);
    assign accept   = (state_q == S_IDLE) && cmd_valid && (cmd_op_e != OP_NONE);
    assign hi_end   = (state_q == S_HIGH) && t_expire;
    assign last_bit = (bit_left_q == CW'(1));

    mw_frame_builder #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) frame_i (
        .op    (cmd_op_e),
        .addr  (cmd_addr),
        .wdata (cmd_wdata),
        .frame (frame),
        .nbits (nbits)
    );

    mw_tx_shifter #(
        .W (FRAME_W)
    ) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (frame),
        .shift     (hi_end),
        .head      (tx_head),
        .head_next (tx_head_next)
    );

    mw_phase_timer #(
        .TW (TW)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_d != state_q),
        .load_len (phase_len),
        .expire   (t_expire)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (accept)   state_d = S_SELECT;
            S_SELECT:   if (t_expire) state_d = S_LOW;
            S_LOW:      if (t_expire) state_d = S_HIGH;
            S_HIGH:     if (t_expire) state_d = last_bit ? S_DESELECT : S_LOW;
            S_DESELECT: if (t_expire) state_d = (op_q == OP_WRITE) ? S_PROGRAM : S_IDLE;
            S_PROGRAM:  if (t_expire) state_d = S_IDLE;
            default:                  state_d = S_IDLE;
        endcase
    end

    // Length of the phase being entered.
    always_comb begin
        unique case (state_d)
            S_SELECT, S_LOW, S_HIGH: phase_len = TW'(CLK_DIV);
            S_DESELECT:              phase_len = TW'(DESEL_LEN);
            S_PROGRAM:               phase_len = TW'(PROG_WAIT);
            default:                 phase_len = TW'(1);
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Command context: latched opcode and remaining bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_NONE;
            bit_left_q <= '0;
        end else if (accept) begin
            op_q       <= cmd_op_e;
            bit_left_q <= nbits;
        end else if (hi_end) begin
            bit_left_q <= bit_left_q - 1'b1;
        end
    end

    // Read capture, MSB first, at the end of each high half in the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (hi_end && (op_q == OP_READ) && (bit_left_q <= CW'(DATA_W))) begin
            rd_q <= {rd_q[DATA_W-2:0], ee_do};
        end
    end

    // Registered outputs, decoded from the state being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b0;
            sk_q   <= 1'b0;
            di_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cs_q   <= state_d inside {S_SELECT, S_LOW, S_HIGH};
            sk_q   <= (state_d == S_HIGH);
            done_q <= (state_q != S_IDLE) && (state_d == S_IDLE);
            if ((state_q == S_SELECT) && (state_d == S_LOW))
                di_q <= tx_head;
            else if (hi_end && (state_d == S_LOW))
                di_q <= tx_head_next;
            else if (!(state_d inside {S_LOW, S_HIGH}))
                di_q <= 1'b0;
        end
    end

    assign ee_cs   = cs_q;
    assign ee_sk   = sk_q;
    assign ee_di   = di_q;
    assign done    = done_q;
    assign busy    = (state_q != S_IDLE);
    assign rd_data = rd_q;

    // R6
    sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    // R6
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    // R7
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ee_cs);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    start_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid) && ($past(cmd_op) != 2'b11)));

    // R11
    prog_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROGRAM) |-> !ee_cs);

endmodule

// File: tb/mw_eeprom_master_tb_top.sv
module mw_eeprom_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int A_W   = 6;
    localparam int D_W   = 16;
    localparam int DIV   = 3;
    localparam int PWAIT = 37;
    localparam int HDR   = A_W + 4;
    localparam int NB_RW = HDR + D_W;
    localparam int NB_EW = HDR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [A_W-1:0] cmd_addr = '0;
    logic [D_W-1:0] cmd_wdata = '0;
    logic busy, done, ee_cs, ee_sk, ee_di;
    logic ee_do = 1'b0;
    logic [D_W-1:0] rd_data;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_master #(
        .ADDR_W    (A_W),
        .DATA_W    (D_W),
        .CLK_DIV   (DIV),
        .PROG_WAIT (PWAIT)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_di     (ee_di),
        .ee_do     (ee_do)
    );

    // Device model and pin monitor, sampled at the falling system edge.
    logic [D_W-1:0] mem [64];
    bit          wr_en;
    logic [63:0] rx, last_rx;
    int          rx_n, last_n, frames;
    logic [3:0]  m_op;
    logic [A_W-1:0] m_addr;
    logic p_cs, p_sk, p_di;
    int run, first_run, min_run, max_run, di_viol, sk_viol, cs_low;
    bit first_pending;

    function automatic logic [D_W-1:0] pat(input int a);
        return D_W'((a * 40503) ^ 16'hA5C3);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] = D_W'(16'h1357 + i * 16'h0101);
            wr_en = 1'b0; rx = '0; last_rx = '0; rx_n = 0; last_n = 0; frames = 0;
            m_op = '0; m_addr = '0; p_cs = 0; p_sk = 0; p_di = 0;
            run = 0; first_run = -1; min_run = 1000000; max_run = 0;
            di_viol = 0; sk_viol = 0; cs_low = 0; first_pending = 1'b1; ee_do = 1'b0;
        end else begin
            if (ee_cs && !p_cs) begin
                rx = '0; rx_n = 0; m_op = '0; m_addr = '0;
            end
            if (ee_sk && !p_sk) begin
                rx = {rx[62:0], ee_di};
                rx_n++;
                if (rx_n == HDR) begin
                    m_op   = rx[HDR-1 -: 4];
                    m_addr = rx[A_W-1:0];
                end
                if (rx_n > HDR && m_op == 4'b0110)
                    ee_do = mem[m_addr][D_W-1-(rx_n-HDR-1)];
            end
            if (!ee_cs && p_cs) begin
                last_rx = rx; last_n = rx_n; frames++;
                if (m_op == 4'b0101 && rx_n == NB_RW && wr_en) mem[m_addr] = rx[D_W-1:0];
                if (rx_n == NB_EW && rx[HDR-1:0] == {4'b0100, 2'b11, {(A_W-2){1'b0}}}) wr_en = 1'b1;
                ee_do = 1'b0;
            end
            if (ee_cs) begin
                if (ee_sk == p_sk) run++;
                else begin
                    if (first_pending) begin first_run = run; first_pending = 1'b0; end
                    if (run < min_run) min_run = run;
                    if (run > max_run) max_run = run;
                    run = 1;
                end
            end else begin
                run = 0;
            end
            if (ee_sk && p_sk && (ee_di != p_di)) di_viol++;
            if (ee_sk && !ee_cs) sk_viol++;
            if (ee_cs) cs_low = 0; else cs_low++;
            p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [1:0] op);
        int n;
        n = (op == 2'b10) ? NB_EW : NB_RW;
        return 4*DIV + 2*DIV*n + ((op == 2'b01) ? PWAIT : 0);
    endfunction

    // Issue one command; optionally present a write while busy at cycle inject_at.
    task automatic run_cmd(input logic [1:0] op, input logic [A_W-1:0] a,
                           input logic [D_W-1:0] wd, input int inject_at,
                           output int lat, output int busy_gaps);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
        @(posedge clk);
        lat = 0; busy_gaps = 0;
        while (1) begin
            @(negedge clk); #1;
            if (lat == 0) cmd_valid = 1'b0;
            if (lat == inject_at) begin
                cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = ~a; cmd_wdata = 16'hDEAD;
            end else if (lat == inject_at + 1) begin
                cmd_valid = 1'b0;
            end
            if (done) break;
            if (!busy) busy_gaps++;
            if (lat > 5000) begin
                check(1'b0, "R8", "done never seen", lat, exp_lat(op));
                break;
            end
            @(posedge clk);
            lat++;
        end
    endtask

    task automatic do_write(input logic [A_W-1:0] a, input logic [D_W-1:0] wd,
                            input logic [D_W-1:0] rd_before);
        int lat, gaps;
        run_cmd(2'b01, a, wd, -1, lat, gaps);
        check(last_n == NB_RW, "R4", "write clock count", last_n, NB_RW);
        check(last_rx == 64'({4'b0101, a, wd}), "R4", "write frame", last_rx, 64'({4'b0101, a, wd}));
        check(lat == exp_lat(2'b01), "R8", "write latency", lat, exp_lat(2'b01));
        check(cs_low == 3*DIV + PWAIT + 1, "R11", "write cs low span", cs_low, 3*DIV + PWAIT + 1);
        check(rd_data == rd_before, "R10", "rd_data after write", rd_data, rd_before);
        check(gaps == 0, "R9", "busy gap", gaps, 0);
    endtask

    task automatic do_read(input logic [A_W-1:0] a, input logic [D_W-1:0] exp, input int inj);
        int lat, gaps, f0;
        f0 = frames;
        run_cmd(2'b00, a, 16'h0, inj, lat, gaps);
        check(last_n == NB_RW, "R3", "read clock count", last_n, NB_RW);
        check(last_rx == 64'({4'b0110, a, 16'h0}), "R3", "read frame", last_rx, 64'({4'b0110, a, 16'h0}));
        check(rd_data == exp, "R3", "read data", rd_data, exp);
        check(lat == exp_lat(2'b00), "R8", "read latency", lat, exp_lat(2'b00));
        check(cs_low == 3*DIV + 1, "R11", "read cs low span", cs_low, 3*DIV + 1);
        check(frames == f0 + 1, "R2", "frames per read", frames, f0 + 1);
        check(gaps == 0, "R9", "busy gap", gaps, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lat, gaps, f0, cs_seen;
        logic [D_W-1:0] keep;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check({ee_cs, ee_sk, ee_di, busy, done} == 5'b0, "R1", "pins in reset",
              {ee_cs, ee_sk, ee_di, busy, done}, 0);
        check(rd_data == '0, "R1", "rd_data in reset", rd_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 reserved code ignored
        f0 = frames; cs_seen = 0;
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_addr = 6'h2A;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            if (busy || ee_cs) cs_seen++;
        end
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(cs_seen == 0, "R2", "reserved code started", cs_seen, 0);
        check(frames == f0, "R2", "reserved code frames", frames, f0);

        // Read of initial contents
        do_read(6'd5, D_W'(16'h1357 + 5 * 16'h0101), -1);

        // R5 write-enable
        keep = rd_data;
        run_cmd(2'b10, 6'h3F, 16'hFFFF, -1, lat, gaps);
        check(last_n == NB_EW, "R5", "ewen clock count", last_n, NB_EW);
        check(last_rx == 64'({4'b0100, 2'b11, 4'b0000}), "R5", "ewen frame",
              last_rx, 64'({4'b0100, 2'b11, 4'b0000}));
        check(lat == exp_lat(2'b10), "R8", "ewen latency", lat, exp_lat(2'b10));
        check(rd_data == keep, "R10", "rd_data after ewen", rd_data, keep);

        // Write sweep over the whole array
        for (int a = 0; a < 64; a++) do_write(A_W'(a), pat(a), keep);
        // Read sweep, descending
        for (int a = 63; a >= 0; a--) do_read(A_W'(a), pat(a), -1);

        // Boundary data words
        keep = rd_data;
        do_write(6'd0, 16'h0000, keep);
        do_write(6'd63, 16'h8001, keep);
        do_read(6'd0, 16'h0000, -1);
        do_read(6'd63, 16'h8001, -1);

        // R2 command during busy is ignored
        do_read(6'd9, pat(9), 20);
        do_read(~6'd9, pat(54), -1);

        // R6 / R7 pin timing
        check(min_run == DIV, "R6", "min half-period", min_run, DIV);
        check(max_run == 2*DIV, "R7", "longest low run", max_run, 2*DIV);
        check(first_run == 2*DIV, "R7", "cs to first clock rise", first_run, 2*DIV);
        check(di_viol == 0, "R6", "data-in moved while clock high", di_viol, 0);
        check(sk_viol == 0, "R6", "clock high without select", sk_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule